// File: doc/BRIEF.md
# Address Translation Cache with Page and Context Invalidation

This block keeps a small set of recent virtual-page to physical-frame translations in front of a page table walker. A lookup that finds its page among the stored translations answers one cycle after it is accepted. A lookup that does not find its page sends the virtual page number to the walker and waits. When the walker answers, the block returns the result to the requester and, unless the walk faulted, stores it for later lookups.

The block does not track page table contents. After software edits a table in memory, it must remove the old translation itself. There are two ways to do this. A page invalidate command removes the single translation for the page that holds the given address. A strobe that marks a load of the page-directory base register discards every stored translation. The one exception is translations marked global in their table entry: these survive the strobe while the global-enable input is high.

Stored translations are searched in parallel. A new translation goes into the lowest-numbered empty slot. When every slot is full, a round-robin pointer picks the slot to replace.

Top module: `tlb_top`

## Requirements
- R1: An accepted lookup (`lk_valid` high while `lk_ready` is high) whose virtual page is stored produces `rsp_valid` with `rsp_hit`=1 in the next cycle. `rsp_paddr` is the stored frame number placed above the request's 12-bit page offset. `rsp_perm` is {user, writable}, taken from table-entry bits 2 and 1.
- R2: An accepted lookup that misses raises `walk_req_valid` in the next cycle, with `walk_req_vpn` equal to `lk_vaddr[31:12]`. The request holds, and `lk_ready` stays low, until `walk_rsp_valid`. One cycle after `walk_rsp_valid`, the block gives `rsp_valid` with `rsp_hit`=0 and the walked frame. A later lookup of the same page then hits.
- R3: A walk faults when `walk_rsp_fault` is high or table-entry bit 0 (present) is clear. A faulting walk is answered with `rsp_fault`=1 and is not stored, so the same page misses again. No stored translation is displaced by it.
- R4: A page invalidate removes only the translation whose page equals `pg_inv_vaddr[31:12]`. Every other stored translation still hits afterwards.
- R5: A `cr3_write` pulse while `glob_en` is low removes every stored translation, including global ones.
- R6: A `cr3_write` pulse while `glob_en` is high removes every translation whose table entry had bit 8 clear. Translations with bit 8 set still hit with their old frame.
- R7: A stored translation is not refreshed when the walker's tables change. It keeps returning the old frame until it is invalidated.
- R8: An install goes into the lowest-numbered empty slot. When all slots are full, it replaces the slot under a round-robin pointer. The pointer starts at slot 0 after reset and advances only on such replacements.
- R9: A page invalidate or `cr3_write` that arrives while a walk is outstanding (including the cycle of `walk_rsp_valid`) still lets that walk's result reach the requester. The result is not stored, so the next lookup of that page misses.
- R10: After reset no translation is stored, `lk_ready` is high, and `rsp_valid` and `walk_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted (no walk in progress) |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response came from a stored translation |
| rsp_fault | output | 1 | Walk faulted; address is not meaningful |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 2 | {user, writable} |
| walk_req_valid | output | 1 | Walk request, held until answered |
| walk_req_vpn | output | 20 | Virtual page to walk |
| walk_rsp_valid | input | 1 | Walker answer pulse |
| walk_rsp_pte | input | 32 | Leaf table entry from the walker |
| walk_rsp_fault | input | 1 | Walker could not complete the walk |
| pg_inv_valid | input | 1 | Invalidate-one-page command |
| pg_inv_vaddr | input | 32 | Address inside the page to invalidate |
| cr3_write | input | 1 | Directory base reload strobe: flush |
| glob_en | input | 1 | Global translations survive the flush |

## Verification
A wrong valid bit shows up as a hit or miss that disagrees with the lookup history. The bench sees this on the next lookup of that page: a wrong hit gives an early `rsp_valid`, and a wrong miss raises `walk_req_valid` one cycle after the request. A corrupted frame or permission field appears in `rsp_paddr`/`rsp_perm` on the first hit. To make every stored entry visible, the bench walks addresses whose expected frame depends on a table generation number. A mis-stepped replacement pointer only becomes visible one or two installs later, when the wrong page misses. The bench's replacement sequence is ordered so that the first wrongly evicted page is looked up immediately.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int PTE_W    = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PFN_W    = PA_W - PG_SHIFT;

    // table entry bit positions the walker's format fixes
    localparam int PTE_PRESENT = 0;
    localparam int PTE_WRITE   = 1;
    localparam int PTE_USER    = 2;
    localparam int PTE_GLOBAL  = 8;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    typedef struct packed {
        logic usr;
        logic wr;
    } perm_t;

    typedef struct packed {
        logic  glob;
        vpn_t  vpn;
        pfn_t  pfn;
        perm_t perm;
    } xlat_t;

    typedef enum logic {ST_IDLE, ST_WALK} fsm_t;

    function automatic xlat_t pte_decode(input vpn_t vpn, input logic [PTE_W-1:0] pte);
        xlat_t x;
        x.glob     = pte[PTE_GLOBAL];
        x.vpn      = vpn;
        x.pfn      = pte[PG_SHIFT +: PFN_W];
        x.perm.usr = pte[PTE_USER];
        x.perm.wr  = pte[PTE_WRITE];
        return x;
    endfunction

    function automatic logic pte_faults(input logic [PTE_W-1:0] pte, input logic walker_fault);
        return walker_fault | ~pte[PTE_PRESENT];
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  vpn_t             lk_vpn,
    output logic             hit,
    output xlat_t            hit_ent,
    input  logic             inv_valid,
    input  vpn_t             inv_vpn,
    input  logic             flush,
    input  logic             keep_glob,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  xlat_t            wr_ent,
    output logic [N-1:0]     valid_vec,
    output logic [N-1:0]     glob_vec
);
    logic [N-1:0] vld_q;
    xlat_t        ent_q [N];
    logic [N-1:0] match;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g]    = vld_q[g] && (ent_q[g].vpn == lk_vpn);
            assign glob_vec[g] = ent_q[g].glob;
        end
    endgenerate

    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_ent = xlat_t'(hit_ent | ent_q[i]);
        end
    end

    assign hit       = |match;
    assign valid_vec = vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    vld_q[i] <= 1'b1;
                    ent_q[i] <= wr_ent;
                end else begin
                    if (flush && !(keep_glob && ent_q[i].glob)) vld_q[i] <= 1'b0;
                    if (inv_valid && (ent_q[i].vpn == inv_vpn))  vld_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign idx = free_found ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (adv && !free_found) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lk_valid,
    input  vpn_t                    lk_vpn,
    input  logic [PG_SHIFT-1:0]     lk_off,
    output logic                    lk_ready,
    input  logic                    hit,
    input  xlat_t                   hit_ent,
    input  logic                    kill,
    output logic                    walk_req_valid,
    output vpn_t                    walk_req_vpn,
    input  logic                    walk_rsp_valid,
    input  logic [PTE_W-1:0]        walk_rsp_pte,
    input  logic                    walk_rsp_fault,
    output logic                    wr_en,
    output xlat_t                   wr_ent,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_fault,
    output logic [PA_W-1:0]         rsp_paddr,
    output perm_t                   rsp_perm
);
    fsm_t                state_q;
    vpn_t                vpn_q;
    logic [PG_SHIFT-1:0] off_q;
    logic                discard_q;
    logic                walk_bad;

    assign walk_bad       = pte_faults(walk_rsp_pte, walk_rsp_fault);
    assign wr_ent         = pte_decode(vpn_q, walk_rsp_pte);
    assign lk_ready       = (state_q == ST_IDLE);
    assign walk_req_valid = (state_q == ST_WALK);
    assign walk_req_vpn   = vpn_q;
    assign wr_en          = (state_q == ST_WALK) && walk_rsp_valid && !walk_bad
                            && !discard_q && !kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            vpn_q     <= '0;
            off_q     <= '0;
            discard_q <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (lk_valid) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= {hit_ent.pfn, lk_off};
                            rsp_perm  <= hit_ent.perm;
                        end else begin
                            vpn_q     <= lk_vpn;
                            off_q     <= lk_off;
                            discard_q <= 1'b0;
                            state_q   <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (kill) discard_q <= 1'b1;
                    if (walk_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_fault <= walk_bad;
                        rsp_paddr <= {wr_ent.pfn, off_q};
                        rsp_perm  <= wr_ent.perm;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    output logic             lk_ready,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_perm,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PTE_W-1:0] walk_rsp_pte,
    input  logic             walk_rsp_fault,
    input  logic             pg_inv_valid,
    input  logic [VA_W-1:0]  pg_inv_vaddr,
    input  logic             cr3_write,
    input  logic             glob_en
);
    logic               lk_hit;
    xlat_t              lk_ent;
    logic               ins_en;
    xlat_t              ins_ent;
    logic [IDX_W-1:0]   ins_idx;
    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_glob;
    perm_t              perm_o;
    logic               unused_inv_off;

    assign unused_inv_off = ^pg_inv_vaddr[PG_SHIFT-1:0];
    assign rsp_perm       = perm_o;

    tlb_store #(.N(ENTRIES)) store_i (
        .clk       (clk),
        .rst       (rst),
        .lk_vpn    (lk_vaddr[VA_W-1:PG_SHIFT]),
        .hit       (lk_hit),
        .hit_ent   (lk_ent),
        .inv_valid (pg_inv_valid),
        .inv_vpn   (pg_inv_vaddr[VA_W-1:PG_SHIFT]),
        .flush     (cr3_write),
        .keep_glob (glob_en),
        .wr_en     (ins_en),
        .wr_idx    (ins_idx),
        .wr_ent    (ins_ent),
        .valid_vec (ent_valid),
        .glob_vec  (ent_glob)
    );

    tlb_victim #(.N(ENTRIES)) victim_i (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (ent_valid),
        .adv       (ins_en),
        .idx       (ins_idx)
    );

    tlb_ctrl ctrl_i (
        .clk            (clk),
        .rst            (rst),
        .lk_valid       (lk_valid),
        .lk_vpn         (lk_vaddr[VA_W-1:PG_SHIFT]),
        .lk_off         (lk_vaddr[PG_SHIFT-1:0]),
        .lk_ready       (lk_ready),
        .hit            (lk_hit),
        .hit_ent        (lk_ent),
        .kill           (pg_inv_valid | cr3_write),
        .walk_req_valid (walk_req_valid),
        .walk_req_vpn   (walk_req_vpn),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_pte   (walk_rsp_pte),
        .walk_rsp_fault (walk_rsp_fault),
        .wr_en          (ins_en),
        .wr_ent         (ins_ent),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_fault      (rsp_fault),
        .rsp_paddr      (rsp_paddr),
        .rsp_perm       (perm_o)
    );
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N = 8,
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             hit,
    input logic [N-1:0]     valid_vec,
    input logic [N-1:0]     glob_vec,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_req_vpn,
    input logic             walk_rsp_valid,
    input logic             walk_rsp_fault,
    input logic             cr3_write,
    input logic             glob_en
);
    a_r1_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_ready && hit |=> rsp_valid && rsp_hit);

    a_r2_miss_starts_walk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_ready && !hit |=> walk_req_valid && !rsp_valid);

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> !lk_ready);

    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid && !walk_rsp_valid |=> walk_req_valid && $stable(walk_req_vpn));

    a_r3_fault_not_stored: assert property (@(posedge clk) disable iff (rst)
        walk_rsp_valid && walk_rsp_fault |=>
            $countones(valid_vec) <= $past($countones(valid_vec)));

    a_r5_flush_all: assert property (@(posedge clk) disable iff (rst)
        cr3_write && !glob_en |=> valid_vec == '0);

    a_r6_only_glob_left: assert property (@(posedge clk) disable iff (rst)
        cr3_write && glob_en |=> (valid_vec & ~glob_vec) == '0);
endmodule

bind tlb_top tlb_chk #(.N(ENTRIES), .VPN_W(tlb_pkg::VPN_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .lk_valid       (lk_valid),
    .lk_ready       (lk_ready),
    .hit            (lk_hit),
    .valid_vec      (ent_valid),
    .glob_vec       (ent_glob),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_fault (walk_rsp_fault),
    .cr3_write      (cr3_write),
    .glob_en        (glob_en)
);

// File: tb/tlb_top_tb_top.sv
module tlb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:0] lk_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_perm;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_rsp_valid;
    logic [31:0] walk_rsp_pte;
    logic        walk_rsp_fault;
    logic        pg_inv_valid = 1'b0;
    logic [31:0] pg_inv_vaddr = '0;
    logic        cr3_write = 1'b0;
    logic        glob_en = 1'b0;

    int checks = 0;
    int errors = 0;
    int gen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tlb_top dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pte(walk_rsp_pte),
        .walk_rsp_fault(walk_rsp_fault), .pg_inv_valid(pg_inv_valid),
        .pg_inv_vaddr(pg_inv_vaddr), .cr3_write(cr3_write), .glob_en(glob_en)
    );

    // table model: frame depends on page and table generation
    function automatic logic [19:0] frame_of(input logic [19:0] vpn, input int g);
        return 20'(vpn * 7 + g * 256 + 1);
    endfunction

    // bit0 present, bit1 writable, bit2 user, bit8 global
    function automatic logic [31:0] pte_of(input logic [19:0] vpn, input int g);
        return {frame_of(vpn, g), 3'b000, vpn[2], 5'b00000, vpn[1], vpn[0], (vpn[7:4] != 4'hF)};
    endfunction

    // walker model: answers three cycles after taking the request
    logic        wk_busy;
    int          wk_cnt;
    logic [19:0] wk_vpn;
    always @(posedge clk) begin
        if (rst) begin
            wk_busy <= 1'b0; wk_cnt <= 0; wk_vpn <= '0;
            walk_rsp_valid <= 1'b0; walk_rsp_pte <= '0; walk_rsp_fault <= 1'b0;
        end else if (walk_rsp_valid) begin
            walk_rsp_valid <= 1'b0;
            wk_busy <= 1'b0;
        end else if (wk_busy) begin
            if (wk_cnt == 0) begin
                walk_rsp_valid <= 1'b1;
                walk_rsp_pte   <= pte_of(wk_vpn, gen);
                walk_rsp_fault <= (wk_vpn[11:8] == 4'hE);
            end else begin
                wk_cnt <= wk_cnt - 1;
            end
        end else if (walk_req_valid) begin
            wk_busy <= 1'b1;
            wk_cnt  <= 2;
            wk_vpn  <= walk_req_vpn;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] va_of(input logic [19:0] vpn);
        return {vpn, 12'(vpn * 12'h111)};
    endfunction

    // ev: 0 none, 1 unrelated page invalidate during walk, 2 cr3 write during walk
    task automatic lookup(input logic [19:0] vpn, input bit exp_hit, input bit exp_fault,
                          input int g, input int ev, input string tag);
        logic [31:0] va;
        int waited;
        va = va_of(vpn);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        if (exp_hit) begin
            chk(rsp_valid === 1'b1, {tag, " hit latency"}, 32'(rsp_valid), 32'd1);
        end else begin
            chk(walk_req_valid === 1'b1 && rsp_valid === 1'b0 && lk_ready === 1'b0,
                {tag, " walk started"}, {29'd0, walk_req_valid, rsp_valid, lk_ready}, 32'h4);
            chk(walk_req_vpn === vpn, {tag, " walk page"}, 32'(walk_req_vpn), 32'(vpn));
            if (ev == 1) begin pg_inv_valid = 1'b1; pg_inv_vaddr = va_of(20'h99); end
            if (ev == 2) cr3_write = 1'b1;
        end
        waited = 0;
        while (rsp_valid !== 1'b1 && waited < 50) begin
            @(negedge clk);
            pg_inv_valid = 1'b0;
            cr3_write = 1'b0;
            waited++;
        end
        chk(rsp_hit === exp_hit, {tag, " hit flag"}, 32'(rsp_hit), 32'(exp_hit));
        chk(rsp_fault === exp_fault, {tag, " fault flag"}, 32'(rsp_fault), 32'(exp_fault));
        if (!exp_fault) begin
            chk(rsp_paddr === {frame_of(vpn, g), va[11:0]}, {tag, " paddr"},
                rsp_paddr, {frame_of(vpn, g), va[11:0]});
            chk(rsp_perm === {vpn[1], vpn[0]}, {tag, " perm"}, 32'(rsp_perm), 32'({vpn[1], vpn[0]}));
        end
    endtask

    task automatic pulse_inv(input logic [19:0] vpn);
        @(negedge clk); pg_inv_valid = 1'b1; pg_inv_vaddr = va_of(vpn);
        @(negedge clk); pg_inv_valid = 1'b0;
    endtask

    task automatic pulse_cr3(input bit ge);
        @(negedge clk); glob_en = ge; cr3_write = 1'b1;
        @(negedge clk); cr3_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(lk_ready === 1'b1 && rsp_valid === 1'b0 && walk_req_valid === 1'b0, "R10 idle after reset",
            {29'd0, lk_ready, rsp_valid, walk_req_valid}, 32'h4);

        // R2 miss then R1 hit, filling slots 0..7 (R8 empty slots first)
        for (int i = 0; i < 8; i++) begin
            lookup(20'(16 + i), 1'b0, 1'b0, 0, 0, "R2 fill miss");
            lookup(20'(16 + i), 1'b1, 1'b0, 0, 0, "R1 fill hit");
        end

        // R7 stale translation after table change
        gen = 1;
        lookup(20'h12, 1'b1, 1'b0, 0, 0, "R7 stale frame kept");

        // R4 single page invalidate
        pulse_inv(20'h12);
        lookup(20'h12, 1'b0, 1'b0, 1, 0, "R4 invalidated page walks");
        for (int i = 0; i < 8; i++) begin
            if (i != 2) lookup(20'(16 + i), 1'b1, 1'b0, 0, 0, "R4 other pages kept");
        end
        lookup(20'h12, 1'b1, 1'b0, 1, 0, "R8 refilled empty slot");

        // R3 faults: present clear, walker fault; neither stored nor evicting
        lookup(20'h0F0, 1'b0, 1'b1, 1, 0, "R3 not present");
        lookup(20'h0F0, 1'b0, 1'b1, 1, 0, "R3 not present again");
        lookup(20'hE00, 1'b0, 1'b1, 1, 0, "R3 walker fault");
        lookup(20'h10, 1'b1, 1'b0, 0, 0, "R3 no eviction by fault");

        // R8 round robin from slot 0 when full
        lookup(20'h20, 1'b0, 1'b0, 1, 0, "R8 replace slot0");
        lookup(20'h11, 1'b1, 1'b0, 0, 0, "R8 slot1 still held");
        lookup(20'h10, 1'b0, 1'b0, 1, 0, "R8 slot0 page evicted");
        lookup(20'h11, 1'b0, 1'b0, 1, 0, "R8 slot1 page evicted");
        lookup(20'h13, 1'b1, 1'b0, 0, 0, "R8 slot3 untouched");

        // R6 flush keeping global (pages 0x14..0x17 have bit 8 set)
        pulse_cr3(1'b1);
        for (int i = 4; i < 8; i++) lookup(20'(16 + i), 1'b1, 1'b0, 0, 0, "R6 global kept");
        lookup(20'h13, 1'b0, 1'b0, 1, 0, "R6 non-global flushed");
        lookup(20'h20, 1'b0, 1'b0, 1, 0, "R6 non-global flushed b");

        // R5 flush everything with global enable low
        pulse_cr3(1'b0);
        lookup(20'h15, 1'b0, 1'b0, 1, 0, "R5 global flushed");
        lookup(20'h20, 1'b0, 1'b0, 1, 0, "R5 all flushed");

        // R9 invalidation during an outstanding walk
        lookup(20'h30, 1'b0, 1'b0, 1, 1, "R9 inv during walk answered");
        lookup(20'h30, 1'b0, 1'b0, 1, 2, "R9 not stored after inv; cr3 during walk");
        lookup(20'h30, 1'b0, 1'b0, 1, 0, "R9 not stored after cr3");
        lookup(20'h30, 1'b1, 1'b0, 1, 0, "R9 normal walk stored");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule